// File: doc/BRIEF.md
# Per-Core Power Level Search Engine

This block picks a supply level for each core of a small multiprocessor so that the estimated total throughput is as high as possible while the estimated total power stays within a budget. Once per management interval a controller hands it, for every core, the power and throughput measured during the last interval and the level the core ran at. It also hands over the power budget. The engine scales each core's samples to every one of the seven levels. Power scales with the cube of the voltage ratio and throughput with the plain ratio. It then walks every combination of per-core levels and returns the best one it found.

Estimation runs first. Two bit-serial dividers fill a per-core table holding one power estimate and one throughput estimate for each level. Enumeration follows. A mixed-radix counter visits one candidate per clock, adds up the table entries it selects, and keeps the best candidate that fits the budget. A request is a valid/ready handshake. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Back-pressure is simply `req_ready` staying low until the answer is out. The answer is held on the outputs and marked by a one-cycle `done` pulse. There is no output handshake.

Top module: `pls_search`

## Requirements
- R1: Level codes 1 to 7 stand for supply voltages of (13+k) x 50 mV. A previous-level code of 0 is treated as level 1. Every assigned level on `lvl_o` (3 bits per core, core c at bits [3c+2:3c]) is always a code from 1 to 7.
- R2: The power estimate of core c at level j is floor(P_c x (13+j)^3 / (13+q)^3), where P_c is the sampled power and q is the core's previous level. `best_pow_o` is the sum of these estimates over the chosen levels.
- R3: The throughput estimate of core c at level j is floor(T_c x (13+j) / (13+q)). `best_thr_o` is the sum of these estimates over the chosen levels.
- R4: The chosen combination has the largest total throughput among all 7^N combinations whose total power is less than or equal to `budget`. The comparison with the budget is inclusive.
- R5: Candidates are visited as a base-7 number with core 0 as the most significant digit and every digit rising from level 1 to level 7. A candidate replaces the held best only on a strictly greater total throughput, so among equal totals the earliest visited candidate wins.
- R6: The held best throughput starts at zero. If no in-budget candidate has a total throughput above zero, then `no_fit` is 1, every core is assigned level 1, and both totals are 0. Otherwise `no_fit` is 0.
- R7: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until `done`. Changes on the data inputs, and on `req_valid`, while the engine is busy have no effect on the answer.
- R8: `done` is high for exactly one cycle. The result outputs take their new values in that same cycle and hold them until the next `done`.
- R9: After reset, `req_ready` is 1, `done` is 0, `no_fit` is 0, all levels are 1 and both totals are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| smp_pow | input | N_CORES*PW | Sampled power per core, core c at [PW*c +: PW] |
| smp_thr | input | N_CORES*TW | Sampled throughput per core |
| prev_lvl | input | N_CORES*3 | Level each core ran at in the last interval |
| budget | input | PW+2+clog2(N_CORES) | Total power budget |
| done | output | 1 | One-cycle pulse, new result on the outputs |
| lvl_o | output | N_CORES*3 | Assigned level per core |
| best_thr_o | output | TW+1+clog2(N_CORES) | Total estimated throughput of the choice |
| best_pow_o | output | PW+2+clog2(N_CORES) | Total estimated power of the choice |
| no_fit | output | 1 | No combination qualified |

## Verification
The bench builds the engine with three cores and 12-bit samples. That gives 343 candidates per search, so each search completes in well under a thousand cycles. At that size the bench can rebuild the whole candidate space arithmetically for every request and hold the design's choice against a brute-force answer. It does this over directed cases and many random sample sets. The directed cases are a budget met with equality, cores with identical samples that force ties, all-zero throughput, an unreachable budget, and a previous level of code 0. Busy-time input changes and the shape of the `done` pulse are checked on each request.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = 3;
  localparam int V_OFS   = 13;
  localparam int VU_W    = 5;
  localparam int VC_W    = 13;

  // Voltage in 50 mV units; code 0 is treated as the lowest level.
  function automatic logic [VU_W-1:0] volt_units(input logic [LVL_W-1:0] lvl);
    int v;
    v = (lvl == '0) ? V_OFS + 1 : V_OFS + int'(lvl);
    return VU_W'(v);
  endfunction

  function automatic logic [VC_W-1:0] volt_cube(input logic [LVL_W-1:0] lvl);
    int v;
    v = int'(volt_units(lvl));
    return VC_W'(v * v * v);
  endfunction
endpackage

// File: rtl/pls_serial_div.sv
module pls_serial_div #(
  parameter int NW = 25,
  parameter int DW = 13,
  parameter int QW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic [QW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] q;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial;
  logic          ge;

  always_comb begin
    trial = {rem, q[NW-1]};
    ge    = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      q    <= num;
      cnt  <= CW'(NW);
      busy <= 1'b1;
    end else if (busy) begin
      rem <= ge ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
      q   <= {q[NW-2:0], ge};
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign quo = q[QW-1:0];

  // Partial remainder must stay below the divisor (R2, R3 estimate exactness)
  assert_rem_below_den_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && (den != '0) |-> rem < den);
endmodule

// File: rtl/pls_estimator.sv
module pls_estimator
  import pls_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 12,
  parameter int TW = 12,
  localparam int EPW = PW + 2,
  localparam int ETW = TW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*PW-1:0]      smp_pow,
  input  logic [N*TW-1:0]      smp_thr,
  input  logic [N*LVL_W-1:0]   prev_lvl,
  output logic                 done,
  output logic [N*NUM_LVL*EPW-1:0] tab_pow,
  output logic [N*NUM_LVL*ETW-1:0] tab_thr
);
  localparam int CIW  = (N > 1) ? $clog2(N) : 1;
  localparam int NPW  = PW + VC_W;
  localparam int NTW  = TW + VU_W;
  localparam int ENT  = N * NUM_LVL;

  typedef enum logic [1:0] {E_IDLE, E_LAUNCH, E_WAIT} est_st_e;
  est_st_e st;

  logic [CIW-1:0]   ci;
  logic [LVL_W-1:0] li;
  logic [PW-1:0]    pow_c;
  logic [TW-1:0]    thr_c;
  logic [LVL_W-1:0] prv_c;
  logic [LVL_W-1:0] cand;
  logic [NPW-1:0]   num_p;
  logic [NTW-1:0]   num_t;
  logic [VC_W-1:0]  den_p;
  logic [VU_W-1:0]  den_t;
  logic             busy_p, busy_t, go;
  logic [EPW-1:0]   quo_p;
  logic [ETW-1:0]   quo_t;
  logic [EPW-1:0]   tp [ENT];
  logic [ETW-1:0]   tt [ENT];

  always_comb begin
    pow_c = smp_pow[int'(ci)*PW +: PW];
    thr_c = smp_thr[int'(ci)*TW +: TW];
    prv_c = prev_lvl[int'(ci)*LVL_W +: LVL_W];
    cand  = li + 1'b1;
    num_p = NPW'(pow_c) * NPW'(volt_cube(cand));
    num_t = NTW'(thr_c) * NTW'(volt_units(cand));
    den_p = volt_cube(prv_c);
    den_t = volt_units(prv_c);
    go    = (st == E_LAUNCH);
  end

  pls_serial_div #(.NW(NPW), .DW(VC_W), .QW(EPW)) u_div_pow (
    .clk(clk), .rst_n(rst_n), .start(go), .num(num_p), .den(den_p),
    .busy(busy_p), .quo(quo_p));

  pls_serial_div #(.NW(NTW), .DW(VU_W), .QW(ETW)) u_div_thr (
    .clk(clk), .rst_n(rst_n), .start(go), .num(num_t), .den(den_t),
    .busy(busy_t), .quo(quo_t));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= E_IDLE;
      ci   <= '0;
      li   <= '0;
      done <= 1'b0;
      for (int e = 0; e < ENT; e++) begin
        tp[e] <= '0;
        tt[e] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          ci <= '0;
          li <= '0;
          st <= E_LAUNCH;
        end
        E_LAUNCH: st <= E_WAIT;
        E_WAIT: if (!busy_p && !busy_t) begin
          tp[int'(ci)*NUM_LVL + int'(li)] <= quo_p;
          tt[int'(ci)*NUM_LVL + int'(li)] <= quo_t;
          st <= E_LAUNCH;
          if (li == LVL_W'(NUM_LVL - 1)) begin
            li <= '0;
            if (ci == CIW'(N - 1)) begin
              done <= 1'b1;
              st   <= E_IDLE;
            end else begin
              ci <= ci + 1'b1;
            end
          end else begin
            li <= li + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  for (genvar e = 0; e < ENT; e++) begin : g_flat
    assign tab_pow[e*EPW +: EPW] = tp[e];
    assign tab_thr[e*ETW +: ETW] = tt[e];
  end

  // Dividers are launched only when both are free (R2, R3)
  assert_launch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_p && !busy_t);
endmodule

// File: rtl/pls_enumerator.sv
module pls_enumerator
  import pls_pkg::*;
#(
  parameter int N   = 4,
  parameter int EPW = 14,
  parameter int ETW = 13,
  parameter int SPW = 16,
  parameter int STW = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N*NUM_LVL*EPW-1:0] tab_pow,
  input  logic [N*NUM_LVL*ETW-1:0] tab_thr,
  input  logic [SPW-1:0]           budget,
  output logic                     fin,
  output logic [N*LVL_W-1:0]       best_lvl,
  output logic [STW-1:0]           best_thr,
  output logic [SPW-1:0]           best_pow,
  output logic                     found
);
  logic [LVL_W-1:0] dig [N];
  logic [LVL_W-1:0] nxt [N];
  logic [SPW-1:0]   sum_p;
  logic [STW-1:0]   sum_t;
  logic             active, last, carry, fits, better;

  always_comb begin
    sum_p = '0;
    sum_t = '0;
    for (int c = 0; c < N; c++) begin
      sum_p = sum_p + SPW'(tab_pow[(c*NUM_LVL + int'(dig[c]))*EPW +: EPW]);
      sum_t = sum_t + STW'(tab_thr[(c*NUM_LVL + int'(dig[c]))*ETW +: ETW]);
    end
    fits   = (sum_p <= budget);
    better = (sum_t > best_thr);
  end

  // Core 0 is the most significant digit; the last core counts fastest.
  always_comb begin
    carry = 1'b1;
    last  = 1'b1;
    for (int c = N - 1; c >= 0; c--) begin
      nxt[c] = dig[c];
      if (dig[c] != LVL_W'(NUM_LVL - 1)) last = 1'b0;
      if (carry) begin
        if (dig[c] == LVL_W'(NUM_LVL - 1)) begin
          nxt[c] = '0;
        end else begin
          nxt[c] = dig[c] + 1'b1;
          carry  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      fin      <= 1'b0;
      found    <= 1'b0;
      best_thr <= '0;
      best_pow <= '0;
      for (int c = 0; c < N; c++) begin
        dig[c]                     <= '0;
        best_lvl[c*LVL_W +: LVL_W] <= LVL_W'(1);
      end
    end else begin
      fin <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        found    <= 1'b0;
        best_thr <= '0;
        best_pow <= '0;
        for (int c = 0; c < N; c++) begin
          dig[c]                     <= '0;
          best_lvl[c*LVL_W +: LVL_W] <= LVL_W'(1);
        end
      end else if (active) begin
        if (fits && better) begin
          found    <= 1'b1;
          best_thr <= sum_t;
          best_pow <= sum_p;
          for (int c = 0; c < N; c++)
            best_lvl[c*LVL_W +: LVL_W] <= dig[c] + 1'b1;
        end
        for (int c = 0; c < N; c++) dig[c] <= nxt[c];
        if (last) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  // Held best never exceeds the budget (R4)
  assert_best_in_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active && found |-> best_pow <= budget);

  // Best throughput only rises during a search (R5)
  assert_best_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> best_thr >= $past(best_thr));

  for (genvar c = 0; c < N; c++) begin : g_dig_chk
    // Each digit stays within the seven levels (R1)
    assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> dig[c] < LVL_W'(NUM_LVL));
  end
endmodule

// File: rtl/pls_search.sv
module pls_search
  import pls_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int PW      = 12,
  parameter int TW      = 12,
  localparam int CW  = $clog2(N_CORES),
  localparam int EPW = PW + 2,
  localparam int ETW = TW + 1,
  localparam int SPW = EPW + CW,
  localparam int STW = ETW + CW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [N_CORES*PW-1:0]    smp_pow,
  input  logic [N_CORES*TW-1:0]    smp_thr,
  input  logic [N_CORES*LVL_W-1:0] prev_lvl,
  input  logic [SPW-1:0]           budget,
  output logic                     done,
  output logic [N_CORES*LVL_W-1:0] lvl_o,
  output logic [STW-1:0]           best_thr_o,
  output logic [SPW-1:0]           best_pow_o,
  output logic                     no_fit
);
  typedef enum logic [1:0] {T_IDLE, T_EST, T_ENUM} top_st_e;
  top_st_e st;

  logic [N_CORES*PW-1:0]    pow_q;
  logic [N_CORES*TW-1:0]    thr_q;
  logic [N_CORES*LVL_W-1:0] prv_q;
  logic [SPW-1:0]           bud_q;
  logic                     accept, est_done, enum_fin, found;
  logic [N_CORES*NUM_LVL*EPW-1:0] tab_pow;
  logic [N_CORES*NUM_LVL*ETW-1:0] tab_thr;
  logic [N_CORES*LVL_W-1:0] best_lvl;
  logic [STW-1:0]           best_thr;
  logic [SPW-1:0]           best_pow;
  logic [N_CORES*LVL_W-1:0] all_low;

  assign req_ready = (st == T_IDLE);
  assign accept    = req_valid && req_ready;

  for (genvar c = 0; c < N_CORES; c++) begin : g_low
    assign all_low[c*LVL_W +: LVL_W] = LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_IDLE;
      pow_q      <= '0;
      thr_q      <= '0;
      prv_q      <= '0;
      bud_q      <= '0;
      done       <= 1'b0;
      lvl_o      <= all_low;
      best_thr_o <= '0;
      best_pow_o <= '0;
      no_fit     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (accept) begin
          pow_q <= smp_pow;
          thr_q <= smp_thr;
          prv_q <= prev_lvl;
          bud_q <= budget;
          st    <= T_EST;
        end
        T_EST: if (est_done) st <= T_ENUM;
        T_ENUM: if (enum_fin) begin
          done       <= 1'b1;
          lvl_o      <= found ? best_lvl : all_low;
          best_thr_o <= found ? best_thr : '0;
          best_pow_o <= found ? best_pow : '0;
          no_fit     <= !found;
          st         <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  pls_estimator #(.N(N_CORES), .PW(PW), .TW(TW)) u_est (
    .clk(clk), .rst_n(rst_n), .start(st == T_EST && !est_done && !est_busy_q),
    .smp_pow(pow_q), .smp_thr(thr_q), .prev_lvl(prv_q),
    .done(est_done), .tab_pow(tab_pow), .tab_thr(tab_thr));

  logic est_busy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   est_busy_q <= 1'b0;
    else if (accept)              est_busy_q <= 1'b0;
    else if (st == T_EST)         est_busy_q <= !est_done;
    else                          est_busy_q <= 1'b0;
  end

  pls_enumerator #(.N(N_CORES), .EPW(EPW), .ETW(ETW), .SPW(SPW), .STW(STW)) u_enum (
    .clk(clk), .rst_n(rst_n), .start(est_done), .tab_pow(tab_pow),
    .tab_thr(tab_thr), .budget(bud_q), .fin(enum_fin), .best_lvl(best_lvl),
    .best_thr(best_thr), .best_pow(best_pow), .found(found));

  // done lasts one cycle (R8)
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Results move only together with done (R8)
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(best_thr_o) && $stable(best_pow_o) && $stable(lvl_o) && $stable(no_fit));

  // Accepted request drops ready on the next cycle (R7)
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // No-fit answer has zero totals (R6)
  assert_nofit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_fit |-> best_thr_o == '0 && best_pow_o == '0);

  for (genvar c = 0; c < N_CORES; c++) begin : g_lvl_chk
    // Assigned levels are always legal codes (R1)
    assert_level_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_o[c*LVL_W +: LVL_W] != '0);
  end
endmodule

// File: tb/pls_search_tb.sv
module pls_search_tb;
  localparam int N   = 3;
  localparam int PW  = 12;
  localparam int TW  = 12;
  localparam int SPW = PW + 2 + $clog2(N);
  localparam int STW = TW + 1 + $clog2(N);
  localparam int NC  = 343;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [N*PW-1:0] smp_pow = '0;
  logic [N*TW-1:0] smp_thr = '0;
  logic [N*3-1:0]  prev_lvl = '0;
  logic [SPW-1:0]  budget = '0;
  logic            done;
  logic [N*3-1:0]  lvl_o;
  logic [STW-1:0]  best_thr_o;
  logic [SPW-1:0]  best_pow_o;
  logic            no_fit;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;

  longint rp [N];
  longint rt [N];
  int     rq [N];
  longint rbud;
  int     e_lvl [N];
  longint e_thr, e_pow;
  bit     e_nf;

  always #4 clk = ~clk;

  pls_search #(.N_CORES(N), .PW(PW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .smp_pow(smp_pow), .smp_thr(smp_thr), .prev_lvl(prev_lvl), .budget(budget),
    .done(done), .lvl_o(lvl_o), .best_thr_o(best_thr_o), .best_pow_o(best_pow_o),
    .no_fit(no_fit));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint vu(input int q);
    return (q == 0) ? 14 : 13 + q;
  endfunction

  // Brute-force reference following R2..R6
  task automatic ref_model();
    longint ep [N][7];
    longint et [N][7];
    longint bt, bp, sp, st;
    int bl [N];
    int d [N];
    bit fnd;
    for (int c = 0; c < N; c++)
      for (int k = 0; k < 7; k++) begin
        ep[c][k] = (rp[c] * (14 + k) ** 3) / (vu(rq[c]) ** 3);
        et[c][k] = (rt[c] * (14 + k)) / vu(rq[c]);
      end
    bt = 0; bp = 0; fnd = 0;
    for (int c = 0; c < N; c++) bl[c] = 1;
    for (int i = 0; i < NC; i++) begin
      d[0] = i / 49; d[1] = (i / 7) % 7; d[2] = i % 7;
      sp = 0; st = 0;
      for (int c = 0; c < N; c++) begin
        sp += ep[c][d[c]];
        st += et[c][d[c]];
      end
      if (sp <= rbud && st > bt) begin
        bt = st; bp = sp; fnd = 1;
        for (int c = 0; c < N; c++) bl[c] = d[c] + 1;
      end
    end
    e_nf = !fnd;
    e_thr = fnd ? bt : 0;
    e_pow = fnd ? bp : 0;
    for (int c = 0; c < N; c++) e_lvl[c] = fnd ? bl[c] : 1;
  endtask

  task automatic run(input string tag);
    bit rdy_bad;
    int w;
    logic [STW-1:0] h_thr;
    logic [SPW-1:0] h_pow;
    logic [N*3-1:0] h_lvl;
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      smp_pow[c*PW +: PW] = PW'(rp[c]);
      smp_thr[c*TW +: TW] = TW'(rt[c]);
      prev_lvl[c*3 +: 3]  = 3'(rq[c]);
    end
    budget = SPW'(rbud);
    chk(req_ready == 1'b1, "R7", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(negedge clk);
    // Busy-time junk on every data input must be ignored (R7)
    smp_pow = {N{12'hABC}};
    smp_thr = {N{12'h5A5}};
    prev_lvl = '0;
    budget = '0;
    rdy_bad = 0;
    w = 0;
    while (!done && w < 5000) begin
      if (req_ready) rdy_bad = 1;
      if (w == 20) req_valid = 1'b0;
      @(negedge clk);
      w++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R8", {tag, " done seen"}, done, 1);
    chk(!rdy_bad, "R7", {tag, " ready low while busy"}, rdy_bad, 0);
    ref_model();
    for (int c = 0; c < N; c++)
      chk(lvl_o[c*3 +: 3] == 3'(e_lvl[c]), "R4 R5", {tag, " level"}, lvl_o[c*3 +: 3], e_lvl[c]);
    chk(best_thr_o == STW'(e_thr), "R3 R4", {tag, " total throughput"}, best_thr_o, e_thr);
    chk(best_pow_o == SPW'(e_pow), "R2", {tag, " total power"}, best_pow_o, e_pow);
    chk(no_fit == e_nf, "R6", {tag, " no_fit"}, no_fit, e_nf);
    h_thr = best_thr_o; h_pow = best_pow_o; h_lvl = lvl_o;
    @(negedge clk);
    chk(done == 1'b0, "R8", {tag, " done one cycle"}, done, 0);
    @(negedge clk);
    chk(best_thr_o == h_thr && best_pow_o == h_pow && lvl_o == h_lvl, "R8",
        {tag, " outputs held"}, best_thr_o, h_thr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(no_fit == 1'b0, "R9", "reset no_fit", no_fit, 0);
    chk(lvl_o == {N{3'd1}}, "R9", "reset levels", lvl_o, 9'o111);
    chk(best_thr_o == 0 && best_pow_o == 0, "R9", "reset totals", best_thr_o, 0);
    rst_n = 1'b1;

    // Generous budget: every core at the top level (R4)
    rp = '{1000, 800, 600}; rt = '{500, 400, 300}; rq = '{4, 4, 4};
    rbud = 65000;
    run("wide");
    // Budget equal to the top-level total: inclusive compare (R4)
    rp = '{2744, 2744, 2744}; rt = '{700, 700, 700}; rq = '{1, 1, 1};
    rbud = 3 * 8000;
    run("equal");
    // Identical cores: ties resolved by visiting order (R5)
    rp = '{1500, 1500, 1500}; rt = '{900, 900, 900}; rq = '{4, 4, 4};
    rbud = 6000;
    run("tie");
    // Unreachable budget (R6)
    rp = '{3000, 3000, 3000}; rt = '{100, 100, 100}; rq = '{7, 7, 7};
    rbud = 10;
    run("tight");
    // Zero throughput everywhere: nothing replaces the cleared best (R6)
    rp = '{100, 100, 100}; rt = '{0, 0, 0}; rq = '{3, 3, 3};
    rbud = 60000;
    run("zerothr");
    // Previous level code 0 acts as level 1 (R1)
    rp = '{1234, 567, 2048}; rt = '{999, 321, 1500}; rq = '{0, 0, 5};
    rbud = 5000;
    run("prev0");
    for (int t = 0; t < 36; t++) begin
      for (int c = 0; c < N; c++) begin
        rp[c] = $urandom_range(4095, 1);
        rt[c] = $urandom_range(4095, 0);
        rq[c] = $urandom_range(7, 1);
      end
      rbud = $urandom_range(30000, 0);
      run("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule